// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block decides where each operand of the instruction now in the execute stage comes from in a five-stage in-order pipeline. It compares the two source register indices held in the decode/execute latch with the destination indices of the two older instructions in the execute/memory and memory/writeback latches. For each ALU operand it then chooses the execute/memory result, the memory/writeback value or the register file read. The choice goes to whichever stage holds the youngest matching producer.

A third, one-bit select serves a store sitting in the execute/memory latch. When the value that store is to write was produced by the instruction now in memory/writeback, typically a load, the select picks the memory/writeback value for the memory's data port. The memory address port never takes a forwarded value, because the address is already complete when it leaves the execute stage. The unit is purely combinational. It includes the three data multiplexers, so it can drop straight into the datapath. Stalls, the register file and the ALU belong elsewhere.

Top module: `fwd_bypass_unit`

## Requirements
- R1: An ALU operand select is code 0 (take execute/memory result) when that operand's source index equals the execute/memory destination.
- R2: An ALU operand select is code 1 (take memory/writeback value) when its source index equals the memory/writeback destination and the execute/memory destination does not match.
- R3: An ALU operand select is code 2 (register file read) when neither later latch matches.
- R4: When both later latches hold the operand's source index, code 0 is chosen.
- R5: A latch whose write-enable input is 0 never produces a match, for the ALU operands or for the store-data select.
- R6: Register index 0 never produces a match, for any select.
- R7: The store-data select is 1 when the execute/memory class is store (class code 2'b10), its data-source index equals the memory/writeback destination, and memory/writeback writes a register.
- R8: The store-data select is 0 whenever the execute/memory class is not store (codes 2'b00 ALU, 2'b01 load, 2'b11 other).
- R9: Each data output equals the input named by its select: operand A/B from xm_result_i, mw_value_i or the matching register file input; store data from mw_value_i when selected, else xm_st_data_i.
- R10: The two ALU operands are resolved independently and may take different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dx_rs1_i | input | 5 | Source index of operand A in decode/execute |
| dx_rs2_i | input | 5 | Source index of operand B in decode/execute |
| xm_rd_i | input | 5 | Destination index in execute/memory |
| xm_we_i | input | 1 | Execute/memory instruction writes a register |
| xm_cls_i | input | 2 | Execute/memory class: 00 ALU, 01 load, 10 store, 11 other |
| xm_st_rs_i | input | 5 | Data-source index of the store in execute/memory |
| mw_rd_i | input | 5 | Destination index in memory/writeback |
| mw_we_i | input | 1 | Memory/writeback instruction writes a register |
| rf_a_i | input | 32 | Register file read for operand A |
| rf_b_i | input | 32 | Register file read for operand B |
| xm_result_i | input | 32 | ALU result held in execute/memory |
| xm_st_data_i | input | 32 | Store data carried in execute/memory |
| mw_value_i | input | 32 | Result or loaded value in memory/writeback |
| sel_a_o | output | 2 | Operand A select code |
| sel_b_o | output | 2 | Operand B select code |
| sel_st_o | output | 1 | Store-data select |
| op_a_o | output | 32 | Selected operand A |
| op_b_o | output | 32 | Selected operand B |
| st_data_o | output | 32 | Selected store data for memory |

## Verification
The bench goes after the cases where both later latches name the same register: a design that checked memory/writeback first would hand an operand a stale value. Writers with the enable clear and writes aimed at register 0 are driven with matching indices, because a unit that ignored either would forward a value that was never written, or would forward non-zero data for the zero register. The store path is tried with the store class, with a load class and with write-enable low. A select that fired for non-stores would corrupt the store data. Operands that need different sources in the same cycle expose any sharing of logic between A and B.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_XM = 2'd0,
    SRC_MW = 2'd1,
    SRC_RF = 2'd2
  } opnd_src_e;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_OTHER = 2'b11
  } xm_cls_e;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             we_i,
  output logic             hit_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // zero register is constant, never forwarded
  assign hit_o = we_i && (dst_i != ZERO_REG) && (src_i == dst_i);
endmodule

// File: rtl/fwd_opnd_sel.sv
module fwd_opnd_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_i,
  input  logic [REG_W-1:0]  xm_rd_i,
  input  logic              xm_we_i,
  input  logic [REG_W-1:0]  mw_rd_i,
  input  logic              mw_we_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] xm_i,
  input  logic [DATA_W-1:0] mw_i,
  output opnd_src_e         sel_o,
  output logic [DATA_W-1:0] data_o
);
  logic xm_hit, mw_hit;

  fwd_src_match #(.REG_W(REG_W)) u_xm_match (
    .src_i(src_i), .dst_i(xm_rd_i), .we_i(xm_we_i), .hit_o(xm_hit)
  );

  fwd_src_match #(.REG_W(REG_W)) u_mw_match (
    .src_i(src_i), .dst_i(mw_rd_i), .we_i(mw_we_i), .hit_o(mw_hit)
  );

  // youngest producer wins
  always_comb begin
    if (xm_hit)      sel_o = SRC_XM;
    else if (mw_hit) sel_o = SRC_MW;
    else             sel_o = SRC_RF;
  end

  always_comb begin
    unique case (sel_o)
      SRC_XM:  data_o = xm_i;
      SRC_MW:  data_o = mw_i;
      default: data_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        xm_cls_i,
  input  logic [REG_W-1:0]  xm_st_rs_i,
  input  logic [REG_W-1:0]  mw_rd_i,
  input  logic              mw_we_i,
  input  logic [DATA_W-1:0] xm_st_data_i,
  input  logic [DATA_W-1:0] mw_i,
  output logic              sel_o,
  output logic [DATA_W-1:0] data_o
);
  logic hit;
  logic is_store;

  fwd_src_match #(.REG_W(REG_W)) u_st_match (
    .src_i(xm_st_rs_i), .dst_i(mw_rd_i), .we_i(mw_we_i), .hit_o(hit)
  );

  assign is_store = (xm_cls_i == CLS_STORE);
  assign sel_o    = is_store && hit;
  assign data_o   = sel_o ? mw_i : xm_st_data_i;
endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [REG_W-1:0]  dx_rs1_i,
  input  logic [REG_W-1:0]  dx_rs2_i,
  input  logic [REG_W-1:0]  xm_rd_i,
  input  logic              xm_we_i,
  input  logic [1:0]        xm_cls_i,
  input  logic [REG_W-1:0]  xm_st_rs_i,
  input  logic [REG_W-1:0]  mw_rd_i,
  input  logic              mw_we_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [DATA_W-1:0] xm_result_i,
  input  logic [DATA_W-1:0] xm_st_data_i,
  input  logic [DATA_W-1:0] mw_value_i,
  output logic [SEL_W-1:0]  sel_a_o,
  output logic [SEL_W-1:0]  sel_b_o,
  output logic              sel_st_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic [DATA_W-1:0] st_data_o
);
  localparam int unsigned N_OPND = 2;

  logic [REG_W-1:0]  src   [N_OPND];
  logic [DATA_W-1:0] rf_rd [N_OPND];
  opnd_src_e         sel   [N_OPND];
  logic [DATA_W-1:0] opnd  [N_OPND];

  assign src[0]   = dx_rs1_i;
  assign src[1]   = dx_rs2_i;
  assign rf_rd[0] = rf_a_i;
  assign rf_rd[1] = rf_b_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fwd_opnd_sel #(.REG_W(REG_W), .DATA_W(DATA_W)) u_sel (
      .src_i   (src[g]),
      .xm_rd_i (xm_rd_i),
      .xm_we_i (xm_we_i),
      .mw_rd_i (mw_rd_i),
      .mw_we_i (mw_we_i),
      .rf_i    (rf_rd[g]),
      .xm_i    (xm_result_i),
      .mw_i    (mw_value_i),
      .sel_o   (sel[g]),
      .data_o  (opnd[g])
    );
  end

  // address path has no mux: formed fully in execute
  fwd_store_sel #(.REG_W(REG_W), .DATA_W(DATA_W)) u_st (
    .xm_cls_i     (xm_cls_i),
    .xm_st_rs_i   (xm_st_rs_i),
    .mw_rd_i      (mw_rd_i),
    .mw_we_i      (mw_we_i),
    .xm_st_data_i (xm_st_data_i),
    .mw_i         (mw_value_i),
    .sel_o        (sel_st_o),
    .data_o       (st_data_o)
  );

  assign sel_a_o = SEL_W'(sel[0]);
  assign sel_b_o = SEL_W'(sel[1]);
  assign op_a_o  = opnd[0];
  assign op_b_o  = opnd[1];
endmodule

// File: rtl/fwd_bypass_chk.sv
module fwd_bypass_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 2
) (
  input logic [REG_W-1:0]  dx_rs1_i,
  input logic [REG_W-1:0]  xm_rd_i,
  input logic              xm_we_i,
  input logic [1:0]        xm_cls_i,
  input logic [REG_W-1:0]  xm_st_rs_i,
  input logic [REG_W-1:0]  mw_rd_i,
  input logic              mw_we_i,
  input logic [DATA_W-1:0] rf_a_i,
  input logic [DATA_W-1:0] xm_result_i,
  input logic [DATA_W-1:0] xm_st_data_i,
  input logic [DATA_W-1:0] mw_value_i,
  input logic [SEL_W-1:0]  sel_a_o,
  input logic              sel_st_o,
  input logic [DATA_W-1:0] op_a_o,
  input logic [DATA_W-1:0] st_data_o
);
  localparam logic [REG_W-1:0] Z = '0;

  always_comb begin
    // R1
    xm_sel_a_chk: assert (!(xm_we_i && xm_rd_i != Z && dx_rs1_i == xm_rd_i) || sel_a_o == 2'd0);
    // R2
    mw_sel_a_chk: assert (sel_a_o != 2'd1 || (mw_we_i && mw_rd_i != Z && dx_rs1_i == mw_rd_i
                          && !(xm_we_i && xm_rd_i == dx_rs1_i)));
    // R3
    legal_sel_a_chk: assert (sel_a_o != 2'd3);
    // R5
    no_we_xm_chk: assert (xm_we_i || sel_a_o != 2'd0);
    // R6
    zero_reg_chk: assert (dx_rs1_i != Z || sel_a_o == 2'd2);
    // R7
    st_cond_chk: assert (!sel_st_o || (mw_we_i && mw_rd_i != Z && xm_st_rs_i == mw_rd_i));
    // R8
    st_cls_chk: assert (xm_cls_i == 2'b10 || !sel_st_o);
    // R9
    op_a_data_chk: assert (op_a_o == (sel_a_o == 2'd0 ? xm_result_i :
                                     sel_a_o == 2'd1 ? mw_value_i : rf_a_i));
    // R9
    st_data_chk: assert (st_data_o == (sel_st_o ? mw_value_i : xm_st_data_i));
  end
endmodule

bind fwd_bypass_unit fwd_bypass_chk #(.REG_W(REG_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_fwd_bypass_unit.sv
module tb_fwd_bypass_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  dx_rs1, dx_rs2, xm_rd, mw_rd, xm_st_rs;
  logic        xm_we, mw_we;
  logic [1:0]  xm_cls;
  logic [31:0] rf_a, rf_b, xm_res, xm_st, mw_val;
  logic [1:0]  sel_a, sel_b;
  logic        sel_st;
  logic [31:0] op_a, op_b, st_data;

  int n_cmp = 0;
  int n_bad = 0;

  fwd_bypass_unit dut (
    .dx_rs1_i(dx_rs1), .dx_rs2_i(dx_rs2), .xm_rd_i(xm_rd), .xm_we_i(xm_we),
    .xm_cls_i(xm_cls), .xm_st_rs_i(xm_st_rs), .mw_rd_i(mw_rd), .mw_we_i(mw_we),
    .rf_a_i(rf_a), .rf_b_i(rf_b), .xm_result_i(xm_res), .xm_st_data_i(xm_st),
    .mw_value_i(mw_val), .sel_a_o(sel_a), .sel_b_o(sel_b), .sel_st_o(sel_st),
    .op_a_o(op_a), .op_b_o(op_b), .st_data_o(st_data)
  );

  // {rs1,rs2,xm_rd,xm_we,mw_rd,mw_we,xm_store,xm_st_rs,exp_a,exp_b,exp_st}
  localparam int NV = 13;
  localparam logic [32:0] VEC [NV] = '{
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, 2'd2, 2'd2, 1'b0},  // R3
    {5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, 2'd0, 2'd2, 1'b0},  // R1
    {5'd4, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, 2'd1, 2'd1, 1'b0},  // R2
    {5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1, 1'b0, 5'd0, 2'd0, 2'd0, 1'b0},  // R4
    {5'd5, 5'd6, 5'd5, 1'b0, 5'd5, 1'b1, 1'b0, 5'd0, 2'd1, 2'd2, 1'b0},  // R5
    {5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0, 1'b0, 5'd0, 2'd2, 2'd2, 1'b0},  // R5
    {5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 2'd2, 2'd2, 1'b0},  // R6
    {5'd7, 5'd8, 5'd8, 1'b1, 5'd7, 1'b1, 1'b0, 5'd0, 2'd1, 2'd0, 1'b0},  // R10
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 1'b1, 5'd9, 2'd2, 2'd2, 1'b1},  // R7
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b0, 1'b1, 5'd9, 2'd2, 2'd2, 1'b0},  // R5 store
    {5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0, 5'd9, 2'd2, 2'd2, 1'b0},  // R8
    {5'd9, 5'd9, 5'd3, 1'b1, 5'd9, 1'b1, 1'b1, 5'd3, 2'd1, 2'd1, 1'b0},  // R7 mismatch
    {5'd31,5'd31,5'd31,1'b1, 5'd30,1'b1, 1'b0, 5'd0, 2'd0, 2'd0, 1'b0}   // R1 top index
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'd0) ? xm_res : (s == 2'd1) ? mw_val : rf;
  endfunction

  task automatic drive(input logic [32:0] v, input logic [1:0] cls);
    @(posedge clk);
    dx_rs1 = v[32:28]; dx_rs2 = v[27:23]; xm_rd = v[22:18]; xm_we = v[17];
    mw_rd = v[16:12]; mw_we = v[11]; xm_cls = v[10] ? 2'b10 : cls; xm_st_rs = v[9:5];
    @(negedge clk);
  endtask

  initial begin
    dx_rs1 = '0; dx_rs2 = '0; xm_rd = '0; mw_rd = '0; xm_st_rs = '0;
    xm_we = 1'b0; mw_we = 1'b0; xm_cls = 2'b00;
    rf_a = 32'h1111_0001; rf_b = 32'h2222_0002; xm_res = 32'h3333_0003;
    xm_st = 32'h4444_0004; mw_val = 32'h5555_0005;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: nothing writes, everything from register file (R3)
    chk("R3 idle sel_a", 32'(sel_a), 32'd2);
    chk("R3 idle sel_b", 32'(sel_b), 32'd2);
    chk("R8 idle sel_st", 32'(sel_st), 32'd0);
    chk("R9 idle st_data", st_data, xm_st);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i], 2'b00);
      chk("R1/R2/R3 sel_a", 32'(sel_a), 32'(VEC[i][4:3]));
      chk("R1/R2/R3 sel_b", 32'(sel_b), 32'(VEC[i][2:1]));
      chk("R7/R8 sel_st", 32'(sel_st), 32'(VEC[i][0]));
      chk("R9 op_a", op_a, pick(VEC[i][4:3], rf_a));
      chk("R9 op_b", op_b, pick(VEC[i][2:1], rf_b));
      chk("R9 st_data", st_data, VEC[i][0] ? mw_val : xm_st);
    end

    // R8: load and other classes with a matching data register
    drive({5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0, 5'd9, 5'd0}, 2'b01);
    chk("R8 load sel_st", 32'(sel_st), 32'd0);
    chk("R8 load st_data", st_data, xm_st);
    drive({5'd1, 5'd2, 5'd3, 1'b1, 5'd9, 1'b1, 1'b0, 5'd9, 5'd0}, 2'b11);
    chk("R8 other sel_st", 32'(sel_st), 32'd0);

    // R6: zero-register writer with matching zero store source
    drive({5'd0, 5'd4, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 5'd0}, 2'b00);
    chk("R6 zero op_a", op_a, rf_a);
    chk("R6 zero st_data", st_data, xm_st);

    // R9: change data with same selects, outputs track
    mw_val = 32'hDEAD_BEEF; xm_res = 32'hCAFE_F00D;
    drive({5'd4, 5'd3, 5'd3, 1'b1, 5'd4, 1'b1, 1'b1, 5'd4, 5'd0}, 2'b00);
    chk("R9 op_a mw", op_a, 32'hDEAD_BEEF);
    chk("R10 op_b xm", op_b, 32'hCAFE_F00D);
    chk("R7 st_data mw", st_data, 32'hDEAD_BEEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule